// File: doc/BRIEF.md
# Four-Channel Vectored Bus Interrupter

This block connects four local interrupt sources to a system bus that has seven prioritised, active-low interrupt request lines. Software gives each source a request level, a vector byte and a few policy bits. When a source's input falls, the block raises the request line for that level. It holds that line until every enabled source pending at that level has been acknowledged.

The bus interrupt handler answers with an acknowledge cycle. It pulls `iack_n` low and puts the acknowledged level on the address lines. The block joins the bus acknowledge daisy chain, and once the chain grant `daisy_in_n` reaches it, it does one of three things:

- If no enabled pending source matches the level, it passes the grant down the chain.
- If the matched source uses internal vectoring, it drives that source's vector and asserts data acknowledge.
- If the matched source uses external vectoring, it asserts an enable strobe with a two-bit channel code, so that the source itself can finish the cycle.

If the grant never arrives, the block does nothing. The register port and the acknowledge logic share one clock. The interrupt inputs are asynchronous and are synchronised inside the block.

Top module: `vbi_top`

## Requirements
- R1: After reset every control register reads 0x00, every vector register reads 0x0F, all of `irq_n` is high, and `dtack_n`, `ext_ack_n` and `daisy_out_n` are high.
- R2: With `cs_n` low in a clock cycle, `rw`=0 writes `wdata` and `rw`=1 loads `rdata` at that edge. `addr[1:0]` picks the channel, and `addr[2]` picks the vector register (1) or the control register (0). Control bits: [2:0] level, [3] auto-disable, [4] enable, [5] external vectoring, [6] auto-clear (stored only), [7] flag.
- R3: A falling edge on `int_n[c]` while enable is set makes channel c pending and sets its flag. While the channel is pending and enabled, `irq_n[L-1]` is low, where L is its level in 1..7.
- R4: A falling edge on a channel whose enable bit is clear changes no register and asserts no request line.
- R5: When several channels are pending at one level, that request line stays low until each of them has been acknowledged. The lowest-numbered channel is served first.
- R6: During an acknowledge cycle (`iack_n` low, level latched from `addr[2:0]` on its falling edge) with `daisy_in_n` high, the block asserts none of `dtack_n`, `ext_ack_n`, `daisy_out_n`, and pending state is kept.
- R7: With `daisy_in_n` low and no enabled pending channel at the latched level, `daisy_out_n` goes low and stays low until `iack_n` rises. Level 0 never matches.
- R8: On a match whose external bit is 0, `rdata` carries that channel's vector and `dtack_n` is low until `iack_n` rises.
- R9: On a match whose external bit is 1, `ext_ack_n` is low and `chan_code` holds the channel number, while `dtack_n` and `daisy_out_n` stay high.
- R10: The acknowledged channel leaves the pending state and its flag clears. Its enable bit clears as well if auto-disable is set.
- R11: A channel with level 0 can set its flag but asserts no request line.
- R12: An interrupt input held low after its request is served does not raise a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_n | input | 4 | Device interrupt inputs, active low, asynchronous |
| cs_n | input | 1 | Register port select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register address; the acknowledged level during an acknowledge cycle |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, or the vector during an internal acknowledge |
| iack_n | input | 1 | Bus interrupt acknowledge, active low |
| daisy_in_n | input | 1 | Daisy-chain grant in, active low |
| daisy_out_n | output | 1 | Daisy-chain grant out, active low |
| irq_n | output | 7 | Bus request lines; bit k is level k+1, active low |
| dtack_n | output | 1 | Data acknowledge for the internal vector, active low |
| ext_ack_n | output | 1 | External vector enable strobe, active low |
| chan_code | output | 2 | Channel being acknowledged externally |

## Verification
The hardest situation to reach is two channels pending at the same level and answered by two separate acknowledge cycles. Both inputs must fall together, and the request line must be seen to stay low between the two cycles. The bench programs channels 0 and 2 with one level and different vectors, pulls both inputs low in the same cycle, and runs two acknowledge cycles, checking the vector order and the request line after each. A second case needs the acknowledge cycle to start while the grant is withheld. The bench holds `daisy_in_n` high through a full cycle, then repeats the cycle with the grant given, to show that the pending request survived.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
    localparam int DW      = 8;
    localparam int B_ADIS  = 3;
    localparam int B_EN    = 4;
    localparam int B_EXT   = 5;
    localparam int B_FLAG  = 7;
    localparam logic [DW-1:0] CTL_RST = 8'h00;
    localparam logic [DW-1:0] VEC_RST = 8'h0F;

    typedef enum logic [2:0] {
        AK_IDLE,
        AK_WAIT,
        AK_INT,
        AK_EXT,
        AK_PASS
    } ak_e;
endpackage

// File: rtl/vbi_insync.sv
module vbi_insync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_n,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic [2:0] sh_d, sh_q;
        always_comb sh_d = {sh_q[1:0], in_n[g]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_d;
        end
        // sh_q[1] is the second synchroniser stage, sh_q[2] its previous value
        assign fall[g] = sh_q[2] & ~sh_q[1];
    end
endmodule

// File: rtl/vbi_pick.sv
module vbi_pick #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/vbi_top.sv
module vbi_top
    import vbi_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NLVL = 7,
    localparam int CW  = $clog2(NCH),
    localparam int AW  = CW + 1,
    localparam int LW  = $clog2(NLVL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  int_n,
    input  logic            cs_n,
    input  logic            rw,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic            iack_n,
    input  logic            daisy_in_n,
    output logic            daisy_out_n,
    output logic [NLVL-1:0] irq_n,
    output logic            dtack_n,
    output logic            ext_ack_n,
    output logic [CW-1:0]   chan_code
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] ctl;
        logic [NCH-1:0][DW-1:0] vec;
        logic [NCH-1:0]         pend;
        ak_e                    st;
        logic [LW-1:0]          lvl;
        logic [CW-1:0]          chan;
        logic [DW-1:0]          rd;
        logic                   iack_prev;
    } st_t;

    st_t q, d;

    logic [NCH-1:0] fall;
    logic [NCH-1:0] match;
    logic           hit;
    logic [CW-1:0]  hit_idx;
    logic [CW-1:0]  sel;
    logic [NLVL-1:0] lvl_act;

    vbi_insync #(.N(NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_n  (int_n),
        .fall  (fall)
    );

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            match[c] = q.pend[c] && q.ctl[c][B_EN] &&
                       (q.ctl[c][LW-1:0] == q.lvl) && (q.lvl != '0);
        end
    end

    vbi_pick #(.N(NCH)) u_pick (
        .req (match),
        .hit (hit),
        .idx (hit_idx)
    );

    assign sel = addr[CW-1:0];

    always_comb begin
        d = q;
        d.iack_prev = iack_n;

        // register port
        if (!cs_n) begin
            if (rw)            d.rd = addr[CW] ? q.vec[sel] : q.ctl[sel];
            else if (addr[CW]) d.vec[sel] = wdata;
            else               d.ctl[sel] = wdata;
        end

        // interrupt capture (applied after a same-cycle write)
        for (int c = 0; c < NCH; c++) begin
            if (fall[c] && d.ctl[c][B_EN]) begin
                d.pend[c]         = 1'b1;
                d.ctl[c][B_FLAG]  = 1'b1;
            end
        end

        // acknowledge sequencer
        case (q.st)
            AK_IDLE: begin
                if (q.iack_prev && !iack_n) begin
                    d.lvl = addr[LW-1:0];
                    d.st  = AK_WAIT;
                end
            end
            AK_WAIT: begin
                if (iack_n) begin
                    d.st = AK_IDLE;
                end else if (!daisy_in_n) begin
                    if (hit) begin
                        d.chan                  = hit_idx;
                        d.pend[hit_idx]         = 1'b0;
                        d.ctl[hit_idx][B_FLAG]  = 1'b0;
                        if (d.ctl[hit_idx][B_ADIS]) d.ctl[hit_idx][B_EN] = 1'b0;
                        d.st = d.ctl[hit_idx][B_EXT] ? AK_EXT : AK_INT;
                    end else begin
                        d.st = AK_PASS;
                    end
                end
            end
            default: begin
                if (iack_n) d.st = AK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctl       <= {NCH{CTL_RST}};
            q.vec       <= {NCH{VEC_RST}};
            q.pend      <= '0;
            q.st        <= AK_IDLE;
            q.lvl       <= '0;
            q.chan      <= '0;
            q.rd        <= '0;
            q.iack_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // request lines
    always_comb begin
        lvl_act = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int l = 0; l < NLVL; l++) begin
                if (q.pend[c] && q.ctl[c][B_EN] && (q.ctl[c][LW-1:0] == LW'(l + 1)))
                    lvl_act[l] = 1'b1;
            end
        end
    end

    assign irq_n       = ~lvl_act;
    assign dtack_n     = (q.st != AK_INT);
    assign ext_ack_n   = (q.st != AK_EXT);
    assign daisy_out_n = (q.st != AK_PASS);
    assign chan_code   = (q.st == AK_EXT) ? q.chan : '0;
    assign rdata       = (q.st == AK_INT) ? q.vec[q.chan] : q.rd;
endmodule

// File: rtl/vbi_top_chk.sv
module vbi_top_chk #(
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iack_n,
    input logic          daisy_in_n,
    input logic          dtack_n,
    input logic          ext_ack_n,
    input logic          daisy_out_n,
    input logic [CW-1:0] chan_code
);
    // R7 R8 R9
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~dtack_n, ~ext_ack_n, ~daisy_out_n}) <= 1);

    // R6
    resp_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dtack_n) || $fell(ext_ack_n) || $fell(daisy_out_n)) |-> $past(!daisy_in_n));

    // R8
    dtack_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> $past(!iack_n));

    // R9
    code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_ack_n && $past(!ext_ack_n)) |-> $stable(chan_code));
endmodule

bind vbi_top vbi_top_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iack_n      (iack_n),
    .daisy_in_n  (daisy_in_n),
    .dtack_n     (dtack_n),
    .ext_ack_n   (ext_ack_n),
    .daisy_out_n (daisy_out_n),
    .chan_code   (chan_code)
);

// File: tb/sim_vbi_top.sv
`timescale 1ns/100ps
module sim_vbi_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] int_n = 4'hF;
    logic       cs_n = 1'b1;
    logic       rw = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       iack_n = 1'b1;
    logic       daisy_in_n = 1'b1;
    logic       daisy_out_n;
    logic [6:0] irq_n;
    logic       dtack_n;
    logic       ext_ack_n;
    logic [1:0] chan_code;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vbi_top u0 (
        .clk(clk), .rst_n(rst_n), .int_n(int_n), .cs_n(cs_n), .rw(rw),
        .addr(addr), .wdata(wdata), .rdata(rdata), .iack_n(iack_n),
        .daisy_in_n(daisy_in_n), .daisy_out_n(daisy_out_n), .irq_n(irq_n),
        .dtack_n(dtack_n), .ext_ack_n(ext_ack_n), .chan_code(chan_code)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; rw = 1'b0; addr = a; wdata = v;
        @(negedge clk); cs_n = 1'b1; rw = 1'b1;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; rw = 1'b1; addr = a;
        @(negedge clk); cs_n = 1'b1; v = rdata;
    endtask

    task automatic fire(logic [3:0] m);
        @(negedge clk); int_n = int_n & ~m;
        cyc(5);
    endtask

    task automatic quiet(logic [3:0] m);
        @(negedge clk); int_n = int_n | m;
        cyc(4);
    endtask

    task automatic ack_go(logic [2:0] lvl, bit grant);
        @(negedge clk); addr = lvl; daisy_in_n = ~grant; iack_n = 1'b0;
        cyc(3);
    endtask

    task automatic ack_end;
        @(negedge clk); iack_n = 1'b1; daisy_in_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 irq_n", irq_n, 7'h7F);
        chk("R1 outputs", {dtack_n, ext_ack_n, daisy_out_n}, 3'b111);
        rd(3'd2, v); chk("R1 ctl2", v, 8'h00);
        rd(3'd5, v); chk("R1 vec1", v, 8'h0F);
    endtask

    task automatic t_regmap;
        logic [7:0] v;
        wr(3'd6, 8'hA5);
        wr(3'd3, 8'h03);
        rd(3'd6, v); chk("R2 vec2", v, 8'hA5);
        rd(3'd3, v); chk("R2 ctl3", v, 8'h03);
        rd(3'd7, v); chk("R2 vec3 untouched", v, 8'h0F);
        rd(3'd2, v); chk("R2 ctl2 untouched", v, 8'h00);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_internal;
        logic [7:0] v;
        wr(3'd0, 8'h12); wr(3'd4, 8'h55);
        fire(4'b0001);
        chk("R3 irq level2", irq_n, 7'h7D);
        rd(3'd0, v); chk("R3 flag set", v, 8'h92);
        ack_go(3'd2, 1);
        chk("R8 dtack", dtack_n, 1'b0);
        chk("R8 vector", rdata, 8'h55);
        chk("R8 others", {ext_ack_n, daisy_out_n}, 2'b11);
        ack_end;
        chk("R10 irq released", irq_n, 7'h7F);
        rd(3'd0, v); chk("R10 flag cleared", v, 8'h12);
        cyc(6);
        chk("R12 held input", irq_n, 7'h7F);
        quiet(4'b0001);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_shared;
        wr(3'd0, 8'h13); wr(3'd2, 8'h13);
        wr(3'd4, 8'h40); wr(3'd6, 8'h42);
        fire(4'b0101);
        chk("R5 irq level3", irq_n, 7'h7B);
        ack_go(3'd3, 1);
        chk("R5 first vector", rdata, 8'h40);
        ack_end;
        chk("R5 line held", irq_n, 7'h7B);
        ack_go(3'd3, 1);
        chk("R5 second vector", rdata, 8'h42);
        chk("R5 dtack", dtack_n, 1'b0);
        ack_end;
        chk("R5 line released", irq_n, 7'h7F);
        quiet(4'b0101);
        wr(3'd0, 8'h00); wr(3'd2, 8'h00);
    endtask

    task automatic t_external;
        logic [7:0] v;
        wr(3'd1, 8'h3D);
        fire(4'b0010);
        rd(3'd1, v); chk("R3 ext flag", v, 8'hBD);
        chk("R3 irq level5", irq_n, 7'h6F);
        ack_go(3'd5, 1);
        chk("R9 ext_ack", ext_ack_n, 1'b0);
        chk("R9 code", chan_code, 2'd1);
        chk("R9 no dtack/pass", {dtack_n, daisy_out_n}, 2'b11);
        ack_end;
        rd(3'd1, v); chk("R10 autodisable", v, 8'h2D);
        chk("R10 irq released", irq_n, 7'h7F);
        quiet(4'b0010);
        fire(4'b0010);
        chk("R4 disabled irq", irq_n, 7'h7F);
        rd(3'd1, v); chk("R4 disabled ctl", v, 8'h2D);
        quiet(4'b0010);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_pass;
        ack_go(3'd2, 1);
        chk("R7 pass", daisy_out_n, 1'b0);
        chk("R7 others", {dtack_n, ext_ack_n}, 2'b11);
        ack_end;
        chk("R7 released", daisy_out_n, 1'b1);
    endtask

    task automatic t_nograng;
        wr(3'd3, 8'h16); wr(3'd7, 8'h77);
        fire(4'b1000);
        ack_go(3'd6, 0);
        cyc(3);
        chk("R6 silent", {dtack_n, ext_ack_n, daisy_out_n}, 3'b111);
        chk("R6 still pending", irq_n, 7'h5F);
        ack_end;
        ack_go(3'd6, 1);
        chk("R6 later dtack", dtack_n, 1'b0);
        chk("R6 later vector", rdata, 8'h77);
        ack_end;
        chk("R6 released", irq_n, 7'h7F);
        quiet(4'b1000);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_disabled;
        logic [7:0] v;
        wr(3'd2, 8'h04);
        fire(4'b0100);
        chk("R4 irq", irq_n, 7'h7F);
        rd(3'd2, v); chk("R4 ctl", v, 8'h04);
        quiet(4'b0100);
    endtask

    task automatic t_level0;
        logic [7:0] v;
        wr(3'd0, 8'h10);
        fire(4'b0001);
        chk("R11 irq", irq_n, 7'h7F);
        rd(3'd0, v); chk("R11 flag", v, 8'h90);
        ack_go(3'd0, 1);
        chk("R7 level0 passes", daisy_out_n, 1'b0);
        chk("R7 level0 dtack", dtack_n, 1'b1);
        ack_end;
        quiet(4'b0001);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset;
        t_regmap;
        t_internal;
        t_shared;
        t_external;
        t_pass;
        t_nograng;
        t_disabled;
        t_level0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule